// File: doc/BRIEF.md
# Linear CCD clock and sampling pulse generator

This block derives every clock and strobe that a linear CCD sensor and its correlated double sampling front end need, from one master clock. A line is framed by a synchronous line-enable input: its rising edge starts a line and its low level ends it at once. Each line begins with a guarded transfer pulse: phase-1 is held high for a guard interval, the transfer pulse is raised for its programmed width, a second guard interval follows, and then the two complementary shift clocks begin to run.

While the shift clocks run, the block places a reset pulse, a reference-sample strobe, a signal-sample strobe and a black-level clamp strobe inside every pixel period. Positions are counted in master clocks. In standard mode a pixel lasts 8 master clocks and positions count from the phase-1 falling edge. In even/odd mode a pixel lasts 16 master clocks and positions count from whichever phase-1 edge came last, so every strobe occurs twice per period. The clamp strobe coincides with the reference strobe, and only during the first programmed number of optical-black pixels of a line. All settings are captured at line start, so a change made during a line takes effect on the next line.

Top module: `ccd_timing_gen`

## Requirements
- R1: During and after reset, with the line enable low, the outputs sit at idle: phase-1 high, phase-2 low, transfer, reset, both sample strobes and clamp low.
- R2: A line starts at the first clock edge where the line enable is sampled high after being sampled low. Starting in the following cycle, phase-1 stays high and phase-2 low for G cycles, then the transfer pulse is high for T cycles, then G more cycles pass with the transfer pulse low, where G and T are the captured guard and transfer-width settings.
- R3: A clock edge at which the line enable is sampled low returns all outputs to the idle levels of R1 in the following cycle, from any point in a line.
- R4: After the second guard interval, phase-1 is high for the first half of each pixel period and low for the second half, phase-2 is always its complement, and the period is 8 master clocks in standard mode (mode input 0) and 16 in even/odd mode (mode input 1). The first pixel cycle has phase-1 high.
- R5: In standard mode, with k the number of cycles since the last phase-1 falling edge (0 in the cycle where phase-1 has just gone low, 0..7), the reset pulse is high exactly when P <= k < P + W, with P the reset position and W the reset width; it does not wrap into the next pixel.
- R6: In even/odd mode the same rule as R5 applies with k counted from the most recent phase-1 edge of either direction (0..7), so the reset pulse appears once per half period.
- R7: The reference-sample strobe is high for exactly the cycles where k equals the reference position and the signal-sample strobe for exactly the cycles where k equals the signal position, with k as in R5 or R6 for the mode.
- R8: The clamp strobe is high exactly when the reference-sample strobe is high and the zero-based pixel index within the line is below the optical-black count; the pixel index saturates at 255.
- R9: All settings are captured at the line start of R2; a change while a line runs affects no output until the next line start.
- R10: A guard setting or transfer-width setting of zero behaves as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_en | input | 1 | Line enable; rising edge starts a line, low ends it |
| cfg_evenodd | input | 1 | 0 standard mode (8-clock pixel), 1 even/odd mode (16-clock pixel) |
| cfg_guard | input | 8 | Guard cycles before and after the transfer pulse |
| cfg_xfer_len | input | 8 | Transfer pulse width in master clocks |
| cfg_rst_pos | input | 4 | Reset pulse start offset from the reference edge |
| cfg_rst_len | input | 4 | Reset pulse width in master clocks |
| cfg_ref_pos | input | 4 | Reference-sample strobe offset |
| cfg_sig_pos | input | 4 | Signal-sample strobe offset |
| cfg_black_cnt | input | 8 | Number of optical-black pixels at line start |
| phi1 | output | 1 | Shift clock phase 1 |
| phi2 | output | 1 | Shift clock phase 2 |
| xfer | output | 1 | Transfer pulse |
| rst_pulse | output | 1 | Sensor reset pulse |
| samp_ref | output | 1 | Reference-level sample strobe |
| samp_sig | output | 1 | Signal-level sample strobe |
| clamp | output | 1 | Black-level clamp strobe |

## Verification
The bench runs a standard-mode line and an even/odd-mode line with distinct strobe positions, so that a mix-up of the edge used for offsets, or of the period, shows on the reset and sample strobes. A reset pulse that would run past the pixel end separates clipping from wrapping, and a short optical-black count against a long one shows whether the clamp follows the pixel index. Settings changed mid-line, zero guard and transfer widths, and a line enable dropped during the transfer pulse show capture at line start, the zero-as-one rule and the abort path to idle.

// File: rtl/ccd_timing_pkg.sv
package ccd_timing_pkg;
  parameter int POS_W = 4;
  parameter int LEN_W = 8;
  parameter int BLK_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_GUARD_PRE  = 3'd1,
    ST_XFER       = 3'd2,
    ST_GUARD_POST = 3'd3,
    ST_PIXEL      = 3'd4
  } line_state_e;

  typedef struct packed {
    logic             evenodd;
    logic [LEN_W-1:0] guard;
    logic [LEN_W-1:0] xfer_len;
    logic [POS_W-1:0] rst_pos;
    logic [POS_W-1:0] rst_len;
    logic [POS_W-1:0] ref_pos;
    logic [POS_W-1:0] sig_pos;
    logic [BLK_W-1:0] black_cnt;
  } line_cfg_t;
endpackage

// File: rtl/ccd_edge_detect.sv
module ccd_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic line_en,
  output logic line_start,
  output logic line_stop
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= line_en;
  end

  assign line_start = line_en & ~en_q;
  assign line_stop  = ~line_en;
endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_timing_pkg::*;
#(
  parameter int STD_PERIOD = 8,
  parameter int EO_PERIOD  = 16,
  parameter int CNT_W      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start,
  input  logic        line_stop,
  input  line_cfg_t   cfg_live,
  output line_state_e state_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic [BLK_W-1:0] pix_d,
  output line_cfg_t   cfg_d
);
  localparam logic [BLK_W-1:0] PIX_MAX = {BLK_W{1'b1}};
  localparam logic [CNT_W-1:0] STD_LAST = CNT_W'(STD_PERIOD - 1);
  localparam logic [CNT_W-1:0] EO_LAST  = CNT_W'(EO_PERIOD - 1);

  line_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] pix_q;
  line_cfg_t        cfg_q;

  logic [LEN_W-1:0] guard_eff;
  logic [LEN_W-1:0] xfer_eff;
  logic [CNT_W-1:0] pix_last;

  assign guard_eff = (cfg_q.guard == '0) ? LEN_W'(1) : cfg_q.guard;
  assign xfer_eff  = (cfg_q.xfer_len == '0) ? LEN_W'(1) : cfg_q.xfer_len;
  assign pix_last  = cfg_q.evenodd ? EO_LAST : STD_LAST;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pix_d   = pix_q;
    cfg_d   = cfg_q;
    if (line_stop) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      pix_d   = '0;
    end else if (line_start) begin
      state_d = ST_GUARD_PRE;
      cnt_d   = '0;
      pix_d   = '0;
      cfg_d   = cfg_live;
    end else begin
      unique case (state_q)
        ST_GUARD_PRE: begin
          if (LEN_W'(cnt_q) >= guard_eff - LEN_W'(1)) begin
            state_d = ST_XFER;
            cnt_d   = '0;
          end else cnt_d = cnt_q + CNT_W'(1);
        end
        ST_XFER: begin
          if (LEN_W'(cnt_q) >= xfer_eff - LEN_W'(1)) begin
            state_d = ST_GUARD_POST;
            cnt_d   = '0;
          end else cnt_d = cnt_q + CNT_W'(1);
        end
        ST_GUARD_POST: begin
          if (LEN_W'(cnt_q) >= guard_eff - LEN_W'(1)) begin
            state_d = ST_PIXEL;
            cnt_d   = '0;
            pix_d   = '0;
          end else cnt_d = cnt_q + CNT_W'(1);
        end
        ST_PIXEL: begin
          if (cnt_q >= pix_last) begin
            cnt_d = '0;
            if (pix_q != PIX_MAX) pix_d = pix_q + BLK_W'(1);
          end else cnt_d = cnt_q + CNT_W'(1);
        end
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pix_q   <= '0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pix_q   <= pix_d;
      cfg_q   <= cfg_d;
    end
  end

  // R4: the pixel-phase counter never leaves the period of the captured mode
  assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PIXEL) |-> (cnt_q <= pix_last));

  // R2: the transfer state is only entered from the first guard interval
  assert_xfer_after_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && $past(state_q) != ST_XFER) |->
      ($past(state_q) == ST_GUARD_PRE));

  // R9: captured settings only move at a line start
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !line_start) |=> $stable(cfg_q));
endmodule

// File: rtl/ccd_pulse_decode.sv
module ccd_pulse_decode
  import ccd_timing_pkg::*;
#(
  parameter int STD_PERIOD = 8,
  parameter int EO_PERIOD  = 16,
  parameter int CNT_W      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  line_state_e state_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [BLK_W-1:0] pix_d,
  input  line_cfg_t   cfg_d,
  output logic        phi1,
  output logic        phi2,
  output logic        xfer,
  output logic        rst_pulse,
  output logic        samp_ref,
  output logic        samp_sig,
  output logic        clamp
);
  localparam int OFF_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] STD_HALF = CNT_W'(STD_PERIOD / 2);
  localparam logic [CNT_W-1:0] EO_HALF  = CNT_W'(EO_PERIOD / 2);

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] off_std;
  logic [CNT_W-1:0] off_eo;
  logic [CNT_W-1:0] off;
  logic [OFF_W-1:0] rst_end;
  logic             in_pix;

  logic phi1_n, phi2_n, xfer_n, rst_n_d, ref_n, sig_n, clamp_n;

  assign half    = cfg_d.evenodd ? EO_HALF : STD_HALF;
  assign off_std = (cnt_d >= STD_HALF) ? cnt_d - STD_HALF : cnt_d + STD_HALF;
  assign off_eo  = (cnt_d >= EO_HALF) ? cnt_d - EO_HALF : cnt_d;
  assign off     = cfg_d.evenodd ? off_eo : off_std;
  assign rst_end = OFF_W'(cfg_d.rst_pos) + OFF_W'(cfg_d.rst_len);
  assign in_pix  = (state_d == ST_PIXEL);

  always_comb begin
    phi1_n  = 1'b1;
    xfer_n  = 1'b0;
    rst_n_d = 1'b0;
    ref_n   = 1'b0;
    sig_n   = 1'b0;
    clamp_n = 1'b0;
    if (state_d == ST_XFER) xfer_n = 1'b1;
    if (in_pix) begin
      phi1_n  = (cnt_d < half);
      rst_n_d = (off >= CNT_W'(cfg_d.rst_pos)) && (OFF_W'(off) < rst_end);
      ref_n   = (off == CNT_W'(cfg_d.ref_pos));
      sig_n   = (off == CNT_W'(cfg_d.sig_pos));
      clamp_n = ref_n && (pix_d < cfg_d.black_cnt);
    end
    phi2_n = ~phi1_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi1      <= 1'b1;
      phi2      <= 1'b0;
      xfer      <= 1'b0;
      rst_pulse <= 1'b0;
      samp_ref  <= 1'b0;
      samp_sig  <= 1'b0;
      clamp     <= 1'b0;
    end else begin
      phi1      <= phi1_n;
      phi2      <= phi2_n;
      xfer      <= xfer_n;
      rst_pulse <= rst_n_d;
      samp_ref  <= ref_n;
      samp_sig  <= sig_n;
      clamp     <= clamp_n;
    end
  end

  assert_phase_compl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phi1 != phi2);

  assert_xfer_guarded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (phi1 && !rst_pulse && !samp_ref && !samp_sig));

  assert_clamp_on_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> samp_ref);
endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_timing_pkg::*;
#(
  parameter int STD_PERIOD = 8,
  parameter int EO_PERIOD  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_en,
  input  logic             cfg_evenodd,
  input  logic [LEN_W-1:0] cfg_guard,
  input  logic [LEN_W-1:0] cfg_xfer_len,
  input  logic [POS_W-1:0] cfg_rst_pos,
  input  logic [POS_W-1:0] cfg_rst_len,
  input  logic [POS_W-1:0] cfg_ref_pos,
  input  logic [POS_W-1:0] cfg_sig_pos,
  input  logic [BLK_W-1:0] cfg_black_cnt,
  output logic             phi1,
  output logic             phi2,
  output logic             xfer,
  output logic             rst_pulse,
  output logic             samp_ref,
  output logic             samp_sig,
  output logic             clamp
);
  localparam int CNT_W = (LEN_W > $clog2(EO_PERIOD) + 1) ? LEN_W : $clog2(EO_PERIOD) + 1;

  logic             line_start, line_stop;
  line_cfg_t        cfg_live;
  line_cfg_t        cfg_d;
  line_state_e      state_d;
  logic [CNT_W-1:0] cnt_d;
  logic [BLK_W-1:0] pix_d;

  assign cfg_live = '{evenodd:   cfg_evenodd,
                      guard:     cfg_guard,
                      xfer_len:  cfg_xfer_len,
                      rst_pos:   cfg_rst_pos,
                      rst_len:   cfg_rst_len,
                      ref_pos:   cfg_ref_pos,
                      sig_pos:   cfg_sig_pos,
                      black_cnt: cfg_black_cnt};

  ccd_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .line_en(line_en),
    .line_start(line_start), .line_stop(line_stop)
  );

  ccd_line_seq #(.STD_PERIOD(STD_PERIOD), .EO_PERIOD(EO_PERIOD), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_stop(line_stop),
    .cfg_live(cfg_live), .state_d(state_d), .cnt_d(cnt_d), .pix_d(pix_d), .cfg_d(cfg_d)
  );

  ccd_pulse_decode #(.STD_PERIOD(STD_PERIOD), .EO_PERIOD(EO_PERIOD), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .cnt_d(cnt_d), .pix_d(pix_d),
    .cfg_d(cfg_d), .phi1(phi1), .phi2(phi2), .xfer(xfer), .rst_pulse(rst_pulse),
    .samp_ref(samp_ref), .samp_sig(samp_sig), .clamp(clamp)
  );

  // R3: a low line enable returns every output to idle one cycle later
  assert_stop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en |=> (phi1 && !phi2 && !xfer && !rst_pulse && !samp_ref && !samp_sig && !clamp));

  // R2: the cycle after a line start is guard time with no transfer pulse
  assert_start_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (phi1 && !xfer));
endmodule

// File: tb/ccd_timing_gen_tb.sv
module ccd_timing_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_en = 1'b0;
  logic cfg_evenodd = 1'b0;
  logic [7:0] cfg_guard = 8'd2, cfg_xfer_len = 8'd3, cfg_black_cnt = 8'd2;
  logic [3:0] cfg_rst_pos = 4'd0, cfg_rst_len = 4'd1, cfg_ref_pos = 4'd2, cfg_sig_pos = 4'd5;
  logic phi1, phi2, xfer, rst_pulse, samp_ref, samp_sig, clamp;

  int checks = 0, fails = 0;
  string scen = "R1";

  always #2 clk = ~clk;

  ccd_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .cfg_evenodd(cfg_evenodd),
    .cfg_guard(cfg_guard), .cfg_xfer_len(cfg_xfer_len), .cfg_rst_pos(cfg_rst_pos),
    .cfg_rst_len(cfg_rst_len), .cfg_ref_pos(cfg_ref_pos), .cfg_sig_pos(cfg_sig_pos),
    .cfg_black_cnt(cfg_black_cnt), .phi1(phi1), .phi2(phi2), .xfer(xfer),
    .rst_pulse(rst_pulse), .samp_ref(samp_ref), .samp_sig(samp_sig), .clamp(clamp)
  );

  // behavioural reference: 0 idle, 1 pre-guard, 2 transfer, 3 post-guard, 4 pixels
  int m_st = 0, m_cnt = 0, m_pix = 0, m_prev = 0;
  int c_eo = 0, c_gd = 1, c_tr = 1, c_rp = 0, c_rl = 0, c_ref = 0, c_sig = 0, c_blk = 0;
  bit e_ph1 = 1, e_tr = 0, e_rs = 0, e_ref = 0, e_sig = 0, e_cl = 0;
  int tr_run = 0, tr_last = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_pix = 0; m_prev = 0;
    end else begin
      if (!line_en) begin
        m_st = 0; m_cnt = 0; m_pix = 0;
      end else if (m_prev == 0) begin
        m_st = 1; m_cnt = 0; m_pix = 0;
        c_eo = cfg_evenodd; c_gd = (cfg_guard == 0) ? 1 : int'(cfg_guard);
        c_tr = (cfg_xfer_len == 0) ? 1 : int'(cfg_xfer_len);
        c_rp = cfg_rst_pos; c_rl = cfg_rst_len; c_ref = cfg_ref_pos;
        c_sig = cfg_sig_pos; c_blk = cfg_black_cnt;
      end else begin
        m_cnt++;
        if (m_st == 1 && m_cnt == c_gd) begin m_st = 2; m_cnt = 0; end
        else if (m_st == 2 && m_cnt == c_tr) begin m_st = 3; m_cnt = 0; end
        else if (m_st == 3 && m_cnt == c_gd) begin m_st = 4; m_cnt = 0; end
        else if (m_st == 4 && m_cnt == (c_eo ? 16 : 8)) begin
          m_cnt = 0;
          if (m_pix < 255) m_pix++;
        end
      end
      m_prev = line_en;
    end
    e_ph1 = 1; e_tr = 0; e_rs = 0; e_ref = 0; e_sig = 0; e_cl = 0;
    if (m_st == 2) e_tr = 1;
    if (m_st == 4) begin
      int off;
      e_ph1 = m_cnt < (c_eo ? 8 : 4);
      off = c_eo ? (m_cnt % 8) : ((m_cnt + 4) % 8);
      e_rs  = (off >= c_rp) && (off < c_rp + c_rl);
      e_ref = (off == c_ref);
      e_sig = (off == c_sig);
      e_cl  = e_ref && (m_pix < c_blk);
    end
  end

  task automatic chk(input bit act, input bit exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s/%s] t=%0t actual=%0b expected=%0b", tag, scen, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      string t_rs;
      t_rs = (m_st == 0) ? "R3" : (c_eo ? "R6" : "R5");
      chk(phi1, e_ph1, "phi1", (m_st == 0) ? "R3" : "R4");
      chk(phi2, !e_ph1, "phi2", (m_st == 0) ? "R3" : "R4");
      chk(xfer, e_tr, "xfer", (m_st == 0) ? "R3" : "R2");
      chk(rst_pulse, e_rs, "rst_pulse", t_rs);
      chk(samp_ref, e_ref, "samp_ref", (m_st == 0) ? "R3" : "R7");
      chk(samp_sig, e_sig, "samp_sig", (m_st == 0) ? "R3" : "R7");
      chk(clamp, e_cl, "clamp", (m_st == 0) ? "R3" : "R8");
      if (xfer) tr_run++;
      else if (tr_run != 0) begin tr_last = tr_run; tr_run = 0; end
    end
  end

  task automatic set_cfg(input bit eo, input int gd, input int tr, input int rp, input int rl,
                         input int rf, input int sg, input int bk);
    cfg_evenodd = eo; cfg_guard = 8'(gd); cfg_xfer_len = 8'(tr);
    cfg_rst_pos = 4'(rp); cfg_rst_len = 4'(rl); cfg_ref_pos = 4'(rf);
    cfg_sig_pos = 4'(sg); cfg_black_cnt = 8'(bk);
  endtask

  task automatic run_line(input int hi, input int lo);
    @(negedge clk); line_en = 1'b1;
    repeat (hi) @(negedge clk);
    line_en = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset values while reset is held
    chk(phi1, 1'b1, "phi1", "R1"); chk(phi2, 1'b0, "phi2", "R1");
    chk(xfer, 1'b0, "xfer", "R1"); chk(rst_pulse, 1'b0, "rst", "R1");
    chk(samp_ref, 1'b0, "ref", "R1"); chk(samp_sig, 1'b0, "sig", "R1");
    chk(clamp, 1'b0, "clamp", "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    scen = "R5_std";
    set_cfg(0, 2, 5, 1, 2, 3, 6, 2);
    run_line(120, 3);
    chk_int(tr_last, 5, "R2 transfer width");

    scen = "R6_eo";
    set_cfg(1, 3, 4, 2, 3, 1, 5, 3);
    run_line(200, 2);
    chk_int(tr_last, 4, "R2 transfer width eo");

    scen = "R5_clip";
    set_cfg(0, 1, 2, 6, 5, 7, 0, 40);
    run_line(150, 2);

    scen = "R9_midline";
    set_cfg(0, 2, 3, 0, 1, 2, 4, 1);
    @(negedge clk); line_en = 1'b1;
    repeat (30) @(negedge clk);
    set_cfg(1, 9, 9, 5, 3, 6, 7, 9);
    repeat (60) @(negedge clk);
    line_en = 1'b0;
    repeat (2) @(negedge clk);
    chk_int(tr_last, 3, "R9 transfer width kept");
    run_line(80, 2);
    chk_int(tr_last, 9, "R9 new width next line");

    scen = "R10_zero";
    set_cfg(0, 0, 0, 0, 8, 4, 1, 255);
    run_line(60, 2);
    chk_int(tr_last, 1, "R10 zero width as one");

    scen = "R3_abort";
    set_cfg(0, 2, 20, 1, 1, 2, 3, 1);
    run_line(8, 3);
    chk(xfer, 1'b0, "xfer", "R3"); chk(phi1, 1'b1, "phi1", "R3");

    scen = "R8_long";
    set_cfg(1, 1, 1, 0, 1, 0, 8, 255);
    run_line(1200, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule